// File: doc/BRIEF.md
# Dual-Channel ATA Task-File Register Block

This block models the device side of two legacy ATA register channels on a byte-wide I/O bus. One strobe carries an address, a direction, an access size and a write byte. The block decodes the address into a channel and a register, updates the stored state on writes, and returns a byte on reads. Each channel serves two drive slots. The error, drive/head, status and soft-reset state belong to the channel. Sector count, sector number and the 16-bit cylinder are kept once for each slot.

A static two-bit kind input tells the block, for every slot, whether a drive is fitted and what type it is. The block runs the soft-reset sequence on the edges of the reset bit in device control. It flags a drive/head write that selects an empty slot, and it answers reads of an empty slot with fixed bytes. The data port, command execution, transfers and interrupts are handled elsewhere.

Read data and the error flag are registered. An access presented on one clock edge shows its result on `bus_rdata` and `bus_err` after that edge, and writes take effect on the same edge.

Top module: `ata_taskfile_regs`

## Requirements
- R1: Channel 0 answers addresses where (addr & 0xFFF8) == 0x01F0 or (addr & 0xFFFE) == 0x03F6. Channel 1 answers addresses where (addr & 0xFFF8) == 0x0170 or (addr & 0xFFFE) == 0x0376. An access to one channel never changes the other.
- R2: After `rst`, each channel holds error 0x01, drive/head 0x00 and status 0x00, with the soft-reset bit clear. Every slot holds sector count 0x01, sector number 0x01 and cylinder 0x0000.
- R3: A device-control write (offset 6 of the control block) that takes bit 2 from 0 to 1 loads status 0x90 and error 0x01.
- R4: A device-control write that takes bit 2 from 1 to 0 does the following. It clears status bit 7 and sets status bit 6. It clears drive/head bits 3:0. In both slots it loads sector count 0x01 and sector number 0x01. It loads the cylinder with 0xEB14 when the slot kind is CD (2) and 0x0000 otherwise.
- R5: A drive/head write (offset 6) stores the byte ORed with 0xA0, and its bit 4 selects the slot. If the selected slot kind is none (0), error bit 2 and status bit 0 are set.
- R6: A read at control-block offset 7 (0x03F7 or 0x0377) returns 0xFF.
- R7: While the selected slot is empty, a drive/head read returns 0xA0 and any other read of that channel returns 0x00, except a read at control-block offset 7.
- R8: A read at offset 1 returns the error register. A read at offset 7 of the command block, or at offset 6 of the control block, returns status.
- R9: Sector count (offset 2), sector number (3), cylinder low (4) and cylinder high (5) are written to and read from the slot chosen by drive/head bit 4.
- R10: A sector-number write changes no other register, and cylinder low keeps its value.
- R11: An access with `bus_size` other than 0, or to an address outside R1, raises `bus_err` in the next cycle. It changes no state, and a read returns 0x00.
- R12: Writes to offset 0 (data) and to offset 7 of the command block (command) change nothing. A data-port read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | I/O port address |
| bus_size | input | 2 | Access width minus one in bytes; only 0 is legal |
| bus_wdata | input | 8 | Write byte |
| slot_kind | input | 8 | Two bits per slot, slot index 2*channel+drive; 0 none, 1 disk, 2 CD |
| bus_rdata | output | 8 | Registered read byte |
| bus_err | output | 1 | Registered illegal-access flag |

## Verification
On every cycle the assertions check the following. A drive/head write always leaves bits 7 and 5 set. Selecting an empty slot raises the abort and error bits. The edges of the soft-reset bit produce their status, error, head and sector-count values. Reads of the alternate address return 0xFF. A wide access is always flagged. Only the bench scenarios can show per-slot separation, the cylinder value that depends on the slot kind after reset release, the absent-drive read bytes, that illegal, data and command writes leave state untouched, and that the two channels stay independent. Those depend on sequences of accesses and read-back.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_DISK = 2'd1,
        SLOT_CD   = 2'd2
    } slot_kind_e;

    typedef enum logic [3:0] {
        RG_DATA, RG_ERRFEAT, RG_SCNT, RG_SNUM, RG_CYLLO,
        RG_CYLHI, RG_DRVHD, RG_CMDST, RG_DEVCTL, RG_ALTADDR
    } tf_reg_e;

    typedef struct packed {
        logic    hit;
        logic    ch;
        tf_reg_e rsel;
    } tf_decode_t;

    localparam logic [15:0] CMD_BLK_MASK = 16'hFFF8;
    localparam logic [15:0] CTL_BLK_MASK = 16'hFFFE;
    localparam logic [15:0] CH0_CMD_BASE = 16'h01F0;
    localparam logic [15:0] CH0_CTL_BASE = 16'h03F6;
    localparam logic [15:0] CH1_CMD_BASE = 16'h0170;
    localparam logic [15:0] CH1_CTL_BASE = 16'h0376;

    localparam int DH_SEL_BIT  = 4;
    localparam int DC_SRST_BIT = 2;
    localparam int ST_BUSY     = 7;
    localparam int ST_READY    = 6;
    localparam int ST_ERROR    = 0;
    localparam int ER_ABORT    = 2;

    localparam logic [7:0]  ERR_INIT      = 8'h01;
    localparam logic [7:0]  ST_SRST_LOAD  = 8'h90;
    localparam logic [7:0]  DH_FIXED_ONES = 8'hA0;
    localparam logic [7:0]  SECT_INIT     = 8'h01;
    localparam logic [15:0] CYL_CD_SIG    = 16'hEB14;

    function automatic tf_reg_e cmd_block_reg(input logic [2:0] off);
        case (off)
            3'd0:    return RG_DATA;
            3'd1:    return RG_ERRFEAT;
            3'd2:    return RG_SCNT;
            3'd3:    return RG_SNUM;
            3'd4:    return RG_CYLLO;
            3'd5:    return RG_CYLHI;
            3'd6:    return RG_DRVHD;
            default: return RG_CMDST;
        endcase
    endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output tf_decode_t        dec
);
    localparam int CH_N = 2;

    logic [CH_N-1:0] cmd_hit, ctl_hit;
    logic [15:0]     a16;

    assign a16 = 16'(addr);

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        localparam logic [15:0] CMD_B = (c == 0) ? CH0_CMD_BASE : CH1_CMD_BASE;
        localparam logic [15:0] CTL_B = (c == 0) ? CH0_CTL_BASE : CH1_CTL_BASE;
        assign cmd_hit[c] = (a16 & CMD_BLK_MASK) == CMD_B;
        assign ctl_hit[c] = (a16 & CTL_BLK_MASK) == CTL_B;
    end

    always_comb begin
        dec.hit  = |(cmd_hit | ctl_hit);
        dec.ch   = cmd_hit[1] | ctl_hit[1];
        if (|cmd_hit) dec.rsel = cmd_block_reg(a16[2:0]);
        else          dec.rsel = a16[0] ? RG_ALTADDR : RG_DEVCTL;
    end
endmodule

// File: rtl/ata_tf_channel.sv
module ata_tf_channel
    import ata_tf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  tf_reg_e       rsel,
    input  logic [DW-1:0] wdata,
    input  slot_kind_e    kind0,
    input  slot_kind_e    kind1,
    output logic [DW-1:0] rd_val
);
    localparam int SLOTS = 2;

    logic [DW-1:0]   err_q, dh_q, st_q;
    logic            srst_q;
    logic [DW-1:0]   scnt_q [SLOTS];
    logic [DW-1:0]   snum_q [SLOTS];
    logic [2*DW-1:0] cyl_q  [SLOTS];
    slot_kind_e      kinds  [SLOTS];
    logic            sel, present;

    assign kinds[0] = kind0;
    assign kinds[1] = kind1;
    assign sel      = dh_q[DH_SEL_BIT];
    assign present  = kinds[sel] != SLOT_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= ERR_INIT;
            dh_q   <= '0;
            st_q   <= '0;
            srst_q <= 1'b0;
            for (int d = 0; d < SLOTS; d++) begin
                scnt_q[d] <= SECT_INIT;
                snum_q[d] <= SECT_INIT;
                cyl_q[d]  <= '0;
            end
        end else if (wr_en) begin
            case (rsel)
                RG_SCNT:  scnt_q[sel] <= wdata;
                RG_SNUM:  snum_q[sel] <= wdata;
                RG_CYLLO: cyl_q[sel][DW-1:0] <= wdata;
                RG_CYLHI: cyl_q[sel][2*DW-1:DW] <= wdata;
                RG_DRVHD: begin
                    dh_q <= wdata | DH_FIXED_ONES;
                    if (kinds[wdata[DH_SEL_BIT]] == SLOT_NONE) begin
                        err_q[ER_ABORT] <= 1'b1;
                        st_q[ST_ERROR]  <= 1'b1;
                    end
                end
                RG_DEVCTL: begin
                    if (!srst_q && wdata[DC_SRST_BIT]) begin
                        st_q  <= ST_SRST_LOAD;
                        err_q <= ERR_INIT;
                    end else if (srst_q && !wdata[DC_SRST_BIT]) begin
                        st_q[ST_BUSY]  <= 1'b0;
                        st_q[ST_READY] <= 1'b1;
                        dh_q[3:0]      <= '0;
                        for (int d = 0; d < SLOTS; d++) begin
                            scnt_q[d] <= SECT_INIT;
                            snum_q[d] <= SECT_INIT;
                            cyl_q[d]  <= (kinds[d] == SLOT_CD) ? CYL_CD_SIG : '0;
                        end
                    end
                    srst_q <= wdata[DC_SRST_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        if (rsel == RG_ALTADDR) begin
            rd_val = '1;
        end else if (!present) begin
            rd_val = (rsel == RG_DRVHD) ? DH_FIXED_ONES : '0;
        end else begin
            case (rsel)
                RG_ERRFEAT:        rd_val = err_q;
                RG_SCNT:           rd_val = scnt_q[sel];
                RG_SNUM:           rd_val = snum_q[sel];
                RG_CYLLO:          rd_val = cyl_q[sel][DW-1:0];
                RG_CYLHI:          rd_val = cyl_q[sel][2*DW-1:DW];
                RG_DRVHD:          rd_val = dh_q;
                RG_CMDST, RG_DEVCTL: rd_val = st_q;
                default:           rd_val = '0;
            endcase
        end
    end

    assert_dh_marks_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rsel == RG_DRVHD) |=> (dh_q[7] && dh_q[5]));

    assert_absent_select_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rsel == RG_DRVHD && kinds[wdata[DH_SEL_BIT]] == SLOT_NONE)
        |=> (err_q[ER_ABORT] && st_q[ST_ERROR]));

    assert_srst_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rsel == RG_DEVCTL && !srst_q && wdata[DC_SRST_BIT])
        |=> (st_q == 8'h90 && err_q == 8'h01));

    assert_srst_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rsel == RG_DEVCTL && srst_q && !wdata[DC_SRST_BIT])
        |=> (!st_q[ST_BUSY] && st_q[ST_READY] && dh_q[3:0] == 4'h0
             && scnt_q[0] == 8'h01 && scnt_q[1] == 8'h01));
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DW     = 8,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [7:0]        slot_kind,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err
);
    localparam int CH_N = 2;

    tf_decode_t    dec;
    logic          legal;
    logic [DW-1:0] ch_rd [CH_N];

    ata_tf_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .dec(dec));

    assign legal = dec.hit && (bus_size == '0);

    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        ata_tf_channel #(.DW(DW)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bus_valid && bus_write && legal && (dec.ch == 1'(c))),
            .rsel  (dec.rsel),
            .wdata (bus_wdata),
            .kind0 (slot_kind_e'(slot_kind[4*c +: 2])),
            .kind1 (slot_kind_e'(slot_kind[4*c+2 +: 2])),
            .rd_val(ch_rd[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_valid && !legal;
            if (bus_valid && !bus_write)
                bus_rdata <= legal ? ch_rd[dec.ch] : '0;
        end
    end

    assert_alt_reads_ff_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_size == '0 &&
         (16'(bus_addr) == 16'h03F7 || 16'(bus_addr) == 16'h0377))
        |=> (bus_rdata == 8'hFF));

    assert_wide_flagged_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size != '0) |=> bus_err);

    assert_err_has_cause_R11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_valid));
endmodule

// File: tb/tb_ata_taskfile_regs.sv
module tb_ata_taskfile_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [7:0]  bus_wdata = '0;
    // slot 0: ch0 disk, slot 1: ch0 CD, slot 2: ch1 none, slot 3: ch1 disk
    logic [7:0]  slot_kind = 8'b01_00_10_01;
    logic [7:0]  bus_rdata;
    logic        bus_err;

    int vectors = 0, miscompares = 0;
    logic [7:0] q_d[$];
    logic       q_chk[$];
    logic       q_e[$];
    string      q_tag[$];

    always #4 clk = ~clk;

    ata_taskfile_regs dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .slot_kind(slot_kind), .bus_rdata(bus_rdata), .bus_err(bus_err));

    task automatic access(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                          input logic [7:0] wd, input logic chk, input logic [7:0] ed,
                          input logic ee, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        q_d.push_back(ed); q_chk.push_back(chk); q_e.push_back(ee); q_tag.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        access(1'b1, a, 2'd0, d, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp_d, input string tag);
        access(1'b0, a, 2'd0, 8'h00, 1'b1, exp_d, 1'b0, tag);
    endtask

    // monitor: result of the access presented at this edge is visible just after it
    always @(posedge clk) begin
        #1;
        if (bus_valid && q_d.size() > 0) begin
            logic [7:0] ed; logic ck; logic ee; string tg;
            ed = q_d.pop_front(); ck = q_chk.pop_front();
            ee = q_e.pop_front(); tg = q_tag.pop_front();
            vectors++;
            if ((ck && bus_rdata !== ed) || bus_err !== ee) begin
                miscompares++;
                $display("FAIL %s: rdata=%02h err=%0b expected rdata=%02h err=%0b",
                         tg, bus_rdata, bus_err, ed, ee);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        vectors++;
        if (bus_rdata !== 8'h00 || bus_err !== 1'b0) begin
            miscompares++;
            $display("FAIL R2 reset outputs: rdata=%02h err=%0b expected 00 0", bus_rdata, bus_err);
        end
        // R2 power-on values, R8 aliases
        rd(16'h01F1, 8'h01, "R2 error init / R8 features reads error");
        rd(16'h01F2, 8'h01, "R2 sector count init");
        rd(16'h01F3, 8'h01, "R2 sector number init");
        rd(16'h01F4, 8'h00, "R2 cylinder low init");
        rd(16'h01F6, 8'h00, "R2 drive/head init");
        rd(16'h01F7, 8'h00, "R8 status via command address");
        rd(16'h03F6, 8'h00, "R8 status via control address");
        // R7 absent drive, R6 alt address
        rd(16'h0176, 8'hA0, "R7 absent drive/head read");
        rd(16'h0172, 8'h00, "R7 absent other read");
        rd(16'h0377, 8'hFF, "R6 alt address ch1");
        rd(16'h03F7, 8'hFF, "R6 alt address ch0");
        // R10 sector number write leaves cylinder low
        wr(16'h01F2, 8'h55, "R9 write count slot0");
        wr(16'h01F3, 8'h66, "R10 write sector number");
        rd(16'h01F4, 8'h00, "R10 cylinder low unchanged");
        rd(16'h01F3, 8'h66, "R10 sector number stored");
        // R5 / R9 per-slot storage
        wr(16'h01F6, 8'h10, "R5 select slot1");
        rd(16'h01F6, 8'hB0, "R5 drive/head ORed with A0");
        rd(16'h01F2, 8'h01, "R9 slot1 count separate");
        wr(16'h01F5, 8'h12, "R9 write cyl high slot1");
        rd(16'h01F5, 8'h12, "R9 cyl high slot1");
        wr(16'h01F6, 8'h0F, "R9 select slot0 head F");
        rd(16'h01F2, 8'h55, "R9 slot0 count kept");
        rd(16'h01F5, 8'h00, "R9 slot0 cyl high separate");
        rd(16'h01F6, 8'hAF, "R5 drive/head head bits");
        // R12 data and command ports
        wr(16'h01F0, 8'hFF, "R12 data write");
        wr(16'h01F7, 8'hEC, "R12 command write");
        rd(16'h01F7, 8'h00, "R12 status unchanged by command");
        rd(16'h01F0, 8'h00, "R12 data read zero");
        rd(16'h01F2, 8'h55, "R12 count unchanged by data write");
        // R11 illegal accesses
        access(1'b0, 16'h01F1, 2'd1, 8'h00, 1'b1, 8'h00, 1'b1, "R11 wide read");
        access(1'b1, 16'h01F2, 2'd1, 8'h99, 1'b0, 8'h00, 1'b1, "R11 wide write");
        access(1'b1, 16'h0200, 2'd0, 8'h99, 1'b0, 8'h00, 1'b1, "R11 unmapped write");
        access(1'b1, 16'h01F8, 2'd0, 8'h99, 1'b0, 8'h00, 1'b1, "R11 unmapped write near block");
        access(1'b0, 16'h03F5, 2'd0, 8'h00, 1'b1, 8'h00, 1'b1, "R11 unmapped read");
        rd(16'h01F2, 8'h55, "R11 state unchanged");
        // R3 soft reset rise
        wr(16'h03F6, 8'h04, "R3 set soft reset");
        rd(16'h01F7, 8'h90, "R3 status after rise");
        rd(16'h01F1, 8'h01, "R3 error after rise");
        rd(16'h03F6, 8'h90, "R3 status via control");
        // R4 soft reset fall
        wr(16'h03F6, 8'h00, "R4 clear soft reset");
        rd(16'h01F7, 8'h50, "R4 status busy clr ready set");
        rd(16'h01F6, 8'hA0, "R4 head zeroed");
        rd(16'h01F2, 8'h01, "R4 count reload slot0");
        rd(16'h01F3, 8'h01, "R4 sector number reload");
        rd(16'h01F4, 8'h00, "R4 disk cylinder low");
        wr(16'h01F6, 8'h10, "R4 select CD slot");
        rd(16'h01F4, 8'h14, "R4 CD cylinder low");
        rd(16'h01F5, 8'hEB, "R4 CD cylinder high");
        rd(16'h01F2, 8'h01, "R4 count reload slot1");
        // R5 absent select on channel 1
        wr(16'h0176, 8'h10, "R5 select present slot");
        rd(16'h0171, 8'h01, "R5 no abort on present select");
        wr(16'h0176, 8'h00, "R5 select absent slot");
        wr(16'h0176, 8'h10, "R5 reselect present slot");
        rd(16'h0171, 8'h05, "R5 abort bit set");
        rd(16'h0177, 8'h01, "R5 status error bit");
        rd(16'h0176, 8'hB0, "R5 ch1 drive/head");
        // R1 channel independence
        rd(16'h0172, 8'h01, "R1 ch1 count untouched by ch0");
        rd(16'h01F7, 8'h50, "R1 ch0 status untouched by ch1");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule